// File: doc/BRIEF.md
# Backlight Pulse-Width Modulator with Committed Configuration

This block produces one pulse-width modulated pin that sets the brightness of a display backlight. Software programs it through a small synchronous register port that has an address, write data, a write strobe and combinational read data. The output frequency comes from two numbers: a clock prescaler, which divides the input clock, and a period count. The on-time is set by a high-width count. The ratio of high width to period is the duty cycle. A larger ratio gives a brighter panel.

Software writes to staging registers. The timing logic does not see these writes until software pulses a commit bit. After that pulse, the timing logic takes the staged values only when the current output period ends, so a running period is never cut short. The high-width field is one bit wider than the period field, so it can express a request for 100 % on-time.

Top module: `bkl_pwm`

## Requirements
- R1: Register map and readback. Offset 0x00 holds the enable in bit 0. Offset 0x08 holds the commit bit in bit 0. Offset 0x10 holds the 10-bit prescaler in bits [25:16]. Offset 0x14 holds the 12-bit period in bits [11:0] and the 13-bit high width in bits [28:16]. A read returns the staged contents. Unused bits and unmapped offsets read as 0.
- R2: Reset clears every staged and active value. After reset every register reads 0 and `pwm_out` is low. Enabling after reset with no commit keeps `pwm_out` low, because the active high width is 0.
- R3: With active prescaler d and period p, one output period lasts (d+1)·(p+1) input clock cycles.
- R4: Each period starts with `pwm_out` high. The output stays high for (d+1)·h input cycles, where h is the active high width, and is low for the rest of the period.
- R5: If h ≥ p+1, `pwm_out` stays high for the whole period. If h = 0, `pwm_out` stays low.
- R6: While the enable bit is 0, `pwm_out` is low and the prescaler and period counters are held at zero. After enable is written to 1, the first output cycle is the start of a period.
- R7: A write to the prescaler, period or high-width fields has no effect on `pwm_out` until a commit.
- R8: A commit is a write of 1 to the commit bit while that bit holds 0. After a commit while enabled, the period in progress finishes with the old values. The new values take effect from the first cycle of the next period.
- R9: A commit while disabled takes effect before enable is next set, so the first enabled period already uses the new values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pwm_out | output | 1 | Backlight PWM output |

## Verification
The bench sweeps small prescaler and period values against every high width from 0 to one above full scale. Its expected output is computed arithmetically for each cycle. An off-by-one period counter, or a duty compare written as ≤, would shift one edge per period. A high width that saturated at the period-field width would drop the 100 % case. The bench commits new values in the middle of a period, close to its end. A design that loaded the values at once would glitch the running period. A design that ignored the pending commit would keep the old waveform. The bench also checks three further cases. Staged writes without a commit must leave the output unchanged. A commit while disabled must already shape the first enabled period. A fresh reset followed by enable must stay dark, which a design that cleared only the staged copies would fail.

// File: rtl/bkl_pwm_pkg.sv
package bkl_pwm_pkg;

   // Byte offsets decoded by the register port (software-visible map)
   localparam logic [15:0] OFS_ENABLE = 16'h0000;
   localparam logic [15:0] OFS_COMMIT = 16'h0008;
   localparam logic [15:0] OFS_CTRL0  = 16'h0010;
   localparam logic [15:0] OFS_CTRL1  = 16'h0014;

   // Field placement inside the control words
   localparam int unsigned DIV_LSB_DEF = 16;
   localparam int unsigned PER_LSB_DEF = 0;
   localparam int unsigned HW_LSB_DEF  = 16;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_ENABLE,
      SEL_COMMIT,
      SEL_CTRL0,
      SEL_CTRL1
   } reg_sel_e;

endpackage

// File: rtl/bkl_pwm_regs.sv
module bkl_pwm_regs
   import bkl_pwm_pkg::*;
#(
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned DIV_W   = 10,
   parameter int unsigned PER_W   = 12,
   parameter int unsigned HW_W    = 13,
   parameter int unsigned DIV_LSB = DIV_LSB_DEF,
   parameter int unsigned PER_LSB = PER_LSB_DEF,
   parameter int unsigned HW_LSB  = HW_LSB_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_we,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              en_o,
   output logic              commit_o,
   output logic [DIV_W-1:0]  div_o,
   output logic [PER_W-1:0]  per_o,
   output logic [HW_W-1:0]   hw_o
);

   reg_sel_e         sel;
   logic             en_q;
   logic             commit_q;
   logic [DIV_W-1:0] div_q;
   logic [PER_W-1:0] per_q;
   logic [HW_W-1:0]  hw_q;
   logic             wdata_unused;

   assign wdata_unused = ^bus_wdata;

   always_comb begin
      sel = SEL_NONE;
      if (bus_addr == ADDR_W'(OFS_ENABLE)) sel = SEL_ENABLE;
      if (bus_addr == ADDR_W'(OFS_COMMIT)) sel = SEL_COMMIT;
      if (bus_addr == ADDR_W'(OFS_CTRL0))  sel = SEL_CTRL0;
      if (bus_addr == ADDR_W'(OFS_CTRL1))  sel = SEL_CTRL1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         commit_q <= 1'b0;
         div_q    <= '0;
         per_q    <= '0;
         hw_q     <= '0;
      end else if (bus_we) begin
         case (sel)
            SEL_ENABLE: en_q     <= bus_wdata[0];
            SEL_COMMIT: commit_q <= bus_wdata[0];
            SEL_CTRL0:  div_q    <= bus_wdata[DIV_LSB +: DIV_W];
            SEL_CTRL1: begin
               per_q <= bus_wdata[PER_LSB +: PER_W];
               hw_q  <= bus_wdata[HW_LSB +: HW_W];
            end
            default: ;
         endcase
      end
   end

   // 0 -> 1 transition of the commit bit requests a transfer
   assign commit_o = bus_we && (sel == SEL_COMMIT) && bus_wdata[0] && !commit_q;

   always_comb begin
      bus_rdata = '0;
      case (sel)
         SEL_ENABLE: bus_rdata[0] = en_q;
         SEL_COMMIT: bus_rdata[0] = commit_q;
         SEL_CTRL0:  bus_rdata[DIV_LSB +: DIV_W] = div_q;
         SEL_CTRL1: begin
            bus_rdata[PER_LSB +: PER_W] = per_q;
            bus_rdata[HW_LSB +: HW_W]   = hw_q;
         end
         default: ;
      endcase
   end

   assign en_o  = en_q;
   assign div_o = div_q;
   assign per_o = per_q;
   assign hw_o  = hw_q;

   // R8: a commit request always leaves the commit bit set
   a_r8_commit_sets_bit: assert property (@(posedge clk) disable iff (!rst_n)
      commit_o |=> commit_q);

   // R1: a second write of 1 without an intervening 0 is not a new request
   a_r1_no_double_commit: assert property (@(posedge clk) disable iff (!rst_n)
      commit_q |-> !commit_o);

endmodule

// File: rtl/bkl_pwm_timer.sv
module bkl_pwm_timer #(
   parameter int unsigned DIV_W   = 10,
   parameter int unsigned PER_W   = 12,
   parameter int unsigned HW_W    = 13,
   parameter bit          REG_OUT = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             commit_i,
   input  logic [DIV_W-1:0] div_i,
   input  logic [PER_W-1:0] per_i,
   input  logic [HW_W-1:0]  hw_i,
   output logic             pwm_o
);

   logic             pending_q;
   logic [DIV_W-1:0] div_a;
   logic [PER_W-1:0] per_a;
   logic [HW_W-1:0]  hw_a;
   logic [DIV_W-1:0] pc_q;
   logic [PER_W-1:0] cnt_q;
   logic             tick;
   logic             period_end;
   logic             load;
   logic             hi;

   assign tick       = (pc_q == div_a);
   assign period_end = tick && (cnt_q == per_a);
   assign load       = pending_q && (!en_i || period_end);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pending_q <= 1'b0;
         div_a     <= '0;
         per_a     <= '0;
         hw_a      <= '0;
      end else begin
         if (commit_i)  pending_q <= 1'b1;
         else if (load) pending_q <= 1'b0;
         if (load) begin
            div_a <= div_i;
            per_a <= per_i;
            hw_a  <= hw_i;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !en_i || period_end) begin
         pc_q  <= '0;
         cnt_q <= '0;
      end else if (tick) begin
         pc_q  <= '0;
         cnt_q <= cnt_q + 1'b1;
      end else begin
         pc_q  <= pc_q + 1'b1;
      end
   end

   assign hi = en_i && (HW_W'(cnt_q) < hw_a);

   generate
      if (REG_OUT) begin : g_out_reg
         logic out_q;
         always_ff @(posedge clk) begin
            if (!rst_n) out_q <= 1'b0;
            else        out_q <= hi;
         end
         assign pwm_o = out_q;
      end else begin : g_out_comb
         assign pwm_o = hi;
         // R6: disabled output is low
         a_r6_low_when_off: assert property (@(posedge clk) disable iff (!rst_n)
            !en_i |-> !pwm_o);
      end
   endgenerate

   // R3: prescaler and period counters stay within the active limits
   a_r3_pc_bound: assert property (@(posedge clk) disable iff (!rst_n)
      en_i |-> (pc_q <= div_a));
   a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      en_i |-> (cnt_q <= per_a));

   // R6: counters are cleared while disabled
   a_r6_hold_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> (pc_q == '0) && (cnt_q == '0));

   // R8: active values only move at a period boundary while running
   a_r8_load_at_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && $past(en_i) && !$past(period_end))
         |-> ($stable(div_a) && $stable(per_a) && $stable(hw_a)));

   // R5: saturated duty is solid high, zero duty is solid low
   a_r5_full_high: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && (hw_a > HW_W'(per_a))) |-> hi);
   a_r5_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_a == '0) |-> !hi);

endmodule

// File: rtl/bkl_pwm.sv
module bkl_pwm
   import bkl_pwm_pkg::*;
#(
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned DIV_W   = 10,
   parameter int unsigned PER_W   = 12,
   parameter int unsigned HW_W    = PER_W + 1,
   parameter bit          REG_OUT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_we,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              pwm_out
);

   localparam int unsigned DIV_LSB = DIV_LSB_DEF;
   localparam int unsigned PER_LSB = PER_LSB_DEF;
   localparam int unsigned HW_LSB  = HW_LSB_DEF;

   generate
      if (HW_W <= PER_W) begin : g_bad_hw
         $error("high-width field must be wider than the period field");
      end
      if (DIV_LSB + DIV_W > DATA_W) begin : g_bad_div
         $error("prescaler field does not fit the data word");
      end
      if ((HW_LSB + HW_W > DATA_W) || (PER_LSB + PER_W > HW_LSB)) begin : g_bad_ctl1
         $error("period/high-width fields overlap or overflow the data word");
      end
      if (ADDR_W < 5 || ADDR_W > 16) begin : g_bad_addr
         $error("address width must cover the register map");
      end
   endgenerate

   logic             en;
   logic             commit;
   logic [DIV_W-1:0] div_s;
   logic [PER_W-1:0] per_s;
   logic [HW_W-1:0]  hw_s;

   bkl_pwm_regs #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .DIV_W  (DIV_W),
      .PER_W  (PER_W),
      .HW_W   (HW_W),
      .DIV_LSB(DIV_LSB),
      .PER_LSB(PER_LSB),
      .HW_LSB (HW_LSB)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_we   (bus_we),
      .bus_rdata(bus_rdata),
      .en_o     (en),
      .commit_o (commit),
      .div_o    (div_s),
      .per_o    (per_s),
      .hw_o     (hw_s)
   );

   bkl_pwm_timer #(
      .DIV_W  (DIV_W),
      .PER_W  (PER_W),
      .HW_W   (HW_W),
      .REG_OUT(REG_OUT)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_i    (en),
      .commit_i(commit),
      .div_i   (div_s),
      .per_i   (per_s),
      .hw_i    (hw_s),
      .pwm_o   (pwm_out)
   );

endmodule

// File: tb/bkl_pwm_tb.sv
module bkl_pwm_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_rdata;
   logic        pwm_out;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   bkl_pwm u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_we   (bus_we),
      .bus_rdata(bus_rdata),
      .pwm_out  (pwm_out)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(posedge clk);
      #1 bus_we = 1'b0;
   endtask

   task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
      @(negedge clk);
      bus_addr = a; bus_we = 1'b0;
      #1 chk(tag, bus_rdata, exp);
   endtask

   function automatic logic exp_out(input int i, input int d, input int p, input int h);
      int n;
      n = (d + 1) * (p + 1);
      return ((i % n) / (d + 1)) < h;
   endfunction

   // configure while disabled, commit, then enable (R9 path)
   task automatic setup(input int d, input int p, input int h);
      wr(8'h10, 32'(d) << 16);
      wr(8'h14, (32'(h) << 16) | 32'(p));
      wr(8'h08, 32'h1);
      wr(8'h08, 32'h0);
      wr(8'h00, 32'h1);
   endtask

   task automatic run_cfg(input int d, input int p, input int h);
      int n, highs, errs, expv;
      n = (d + 1) * (p + 1);
      highs = 0; errs = 0;
      setup(d, p, h);
      for (int i = 0; i < 2 * n; i++) begin
         @(negedge clk);
         if (pwm_out) highs++;
         if (pwm_out !== exp_out(i, d, p, h)) errs++;
         if (i == 0)
            chk((h == 0) ? "R6_first_zero" : "R6_first_high", 32'(pwm_out), 32'(h != 0));
      end
      chk((h == 0 || h > p) ? "R5_saturate" : "R4_waveform", errs, 0);
      expv = 2 * (d + 1) * ((h > p + 1) ? p + 1 : h);
      chk("R3_R9_highcount", highs, expv);
      wr(8'h00, 32'h0);
      @(negedge clk);
      chk("R6_off_low", 32'(pwm_out), 0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R2: reset state
      @(negedge clk);
      chk("R2_out_low", 32'(pwm_out), 0);
      rd_chk("R2_en", 8'h00, 0);
      rd_chk("R2_commit", 8'h08, 0);
      rd_chk("R2_ctrl0", 8'h10, 0);
      rd_chk("R2_ctrl1", 8'h14, 0);

      // R1: readback masks and unmapped offsets
      wr(8'h10, 32'hFFFF_FFFF);
      rd_chk("R1_ctrl0", 8'h10, 32'h03FF_0000);
      wr(8'h14, 32'hFFFF_FFFF);
      rd_chk("R1_ctrl1", 8'h14, 32'h1FFF_0FFF);
      wr(8'h08, 32'hFFFF_FFFF);
      rd_chk("R1_commit", 8'h08, 32'h1);
      wr(8'h08, 32'h0);
      rd_chk("R1_commit_clr", 8'h08, 32'h0);
      rd_chk("R1_unmapped04", 8'h04, 0);
      rd_chk("R1_unmapped0c", 8'h0C, 0);
      rd_chk("R1_unmapped18", 8'h18, 0);
      chk("R1_out_still_low", 32'(pwm_out), 0);

      // R3/R4/R5/R6/R9: sweep of small configurations
      for (int d = 0; d < 3; d++) begin
         for (int pi = 0; pi < 4; pi++) begin
            int p;
            p = (pi == 3) ? 5 : pi;
            for (int h = 0; h <= p + 2; h++) run_cfg(d, p, h);
         end
      end
      // R5: largest high width
      run_cfg(1, 2, 13'h1FFF);

      // R7/R8: staged writes mid-run, commit late in a period
      setup(1, 3, 2);
      begin
         int errs7, errs8;
         errs7 = 0; errs8 = 0;
         for (int i = 0; i < 40; i++) begin
            logic e;
            @(negedge clk);
            e = (i < 24) ? exp_out(i, 1, 3, 2) : exp_out(i - 24, 0, 2, 1);
            if (pwm_out !== e) begin
               if (i < 21) errs7++; else errs8++;
            end
            bus_we = 1'b0;
            if (i == 2)  begin bus_addr = 8'h10; bus_wdata = 32'h0;             bus_we = 1'b1; end
            if (i == 3)  begin bus_addr = 8'h14; bus_wdata = (32'd1 << 16) | 2; bus_we = 1'b1; end
            if (i == 21) begin bus_addr = 8'h08; bus_wdata = 32'h1;             bus_we = 1'b1; end
            if (i == 22) begin bus_addr = 8'h08; bus_wdata = 32'h0;             bus_we = 1'b1; end
         end
         bus_we = 1'b0;
         chk("R7_staged_no_effect", errs7, 0);
         chk("R8_boundary_load", errs8, 0);
      end
      wr(8'h00, 32'h0);

      // R9: explicit commit while disabled
      setup(0, 1, 1);
      @(negedge clk);
      chk("R9_first_high", 32'(pwm_out), 1);
      @(negedge clk);
      chk("R9_second_low", 32'(pwm_out), 0);
      wr(8'h00, 32'h0);

      // R2: reset clears active copies too
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      rd_chk("R2_ctrl1_after", 8'h14, 0);
      wr(8'h00, 32'h1);
      begin
         int highs;
         highs = 0;
         for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (pwm_out) highs++;
         end
         chk("R2_active_cleared", highs, 0);
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule